// File: doc/BRIEF.md
# Control-Transfer Target Generator

This block works out the next fetch address for a control-transfer instruction in a 32-bit pipeline where every instruction is four bytes long and word aligned. It takes the address of the current instruction, a 2-bit mode, the raw immediate field of the instruction and the value of a source register. One cycle after a request it presents the target address with a valid strobe. In register mode it also presents a flag that marks a target that is not word aligned.

There are four modes. The relative branch moves forward or backward a signed number of instructions from the following instruction. The region jump keeps the top address bits of the following instruction and replaces all lower bits with the immediate. The register jump uses the register value as it is. The sequential mode just steps to the next instruction. None of the immediate modes encodes the two low address bits: they are always zero. That gives the relative mode four times the reach of its field. Evaluating branch conditions and driving the fetch unit are the jobs of neighbouring blocks.

A two-state machine controls the output strobe. The states are ST_IDLE and ST_ISSUE. The machine moves from ST_IDLE to ST_ISSUE on a request, stays in ST_ISSUE while requests come back to back, and returns from ST_ISSUE to ST_IDLE in a cycle with no request. The valid strobe is high exactly while the machine is in ST_ISSUE.

Top module: `branch_target_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it, valid_o, misalign_o and tgt_o are all zero.
- R2: valid_o is high in a cycle exactly when req_i was high at the previous rising clock edge. Back-to-back requests keep valid_o high and each presents its own target.
- R3: In mode 2'b00 (relative), the target is pc_i + 4 plus imm_i[15:0] sign-extended and shifted left by two, taken modulo 2^32. This covers both forward and backward offsets, including the most negative offset 16'h8000.
- R4: In modes 2'b00, 2'b01 and 2'b11 the value of reg_i has no effect on tgt_o or misalign_o.
- R5: In mode 2'b01 (region), the target is bits 31:28 of pc_i + 4, followed by imm_i[25:0], followed by two zero bits. The sum pc_i + 4 wraps modulo 2^32, so a current address of 32'hFFFF_FFFC selects region 0.
- R6: In mode 2'b10 (register), the target is reg_i unchanged, including its two low bits.
- R7: misalign_o is high exactly when the captured request was in mode 2'b10 and reg_i[1:0] was not 2'b00.
- R8: In mode 2'b11 (sequential), the target is pc_i + 4 modulo 2^32.
- R9: A cycle with req_i low leaves tgt_o and misalign_o at the values of the last request, whatever the other inputs do.
- R10: In mode 2'b00, imm_i[25:16] has no effect on the target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Compute a target from the inputs at this edge |
| mode_i | input | 2 | 00 relative, 01 region, 10 register, 11 sequential |
| pc_i | input | 32 | Address of the current instruction |
| imm_i | input | 26 | Raw immediate field; relative mode uses bits 15:0 |
| reg_i | input | 32 | Source register value for register mode |
| tgt_o | output | 32 | Target address, registered |
| valid_o | output | 1 | High one cycle after each request |
| misalign_o | output | 1 | Register target not word aligned |

## Verification
The bench draws random requests in all four modes and compares each result with a model built from the formulas above. With random current addresses, a fault in the region slice or in the pc + 4 step shows up in the high bits. Directed relative cases use small positive offsets, all-ones offsets and the most negative offset, which separates correct sign extension and scaling from zero extension or a missing shift. Address wrap at the top of memory, register values with each low-bit pattern, and junk in the unused immediate and register bits show whether ignored inputs really stay ignored. Idle cycles with scrambled inputs, and requests issued back to back, test the hold behaviour and the valid strobe.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        MODE_REL    = 2'b00,
        MODE_REGION = 2'b01,
        MODE_REG    = 2'b10,
        MODE_SEQ    = 2'b11
    } bt_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } bt_state_e;

endpackage

// File: rtl/bt_rel_calc.sv
module bt_rel_calc #(
    parameter int ADDR_W  = 32,
    parameter int REL_W   = 16,
    parameter int ALIGN_B = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [REL_W-1:0]  off_i,
    output logic [ADDR_W-1:0] tgt_o
);
    localparam int EXT_W = ADDR_W - REL_W - ALIGN_B;

    logic [ADDR_W-1:0] off_bytes;

    // scale the instruction count to bytes and sign-extend to full width
    assign off_bytes = {{EXT_W{off_i[REL_W-1]}}, off_i, {ALIGN_B{1'b0}}};
    assign tgt_o     = base_i + off_bytes;

endmodule

// File: rtl/bt_region_calc.sv
module bt_region_calc #(
    parameter int ADDR_W  = 32,
    parameter int ABS_W   = 26,
    parameter int ALIGN_B = 2
) (
    input  logic [ADDR_W-ABS_W-ALIGN_B-1:0] region_i,
    input  logic [ABS_W-1:0]                field_i,
    output logic [ADDR_W-1:0]               tgt_o
);
    // region bits above, word-aligned field below
    assign tgt_o = {region_i, field_i, {ALIGN_B{1'b0}}};

endmodule

// File: rtl/bt_out_stage.sv
module bt_out_stage
    import bt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ALIGN_B = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  bt_mode_e          mode_i,
    input  logic [ADDR_W-1:0] rel_tgt_i,
    input  logic [ADDR_W-1:0] region_tgt_i,
    input  logic [ADDR_W-1:0] seq_tgt_i,
    input  logic [ADDR_W-1:0] reg_val_i,
    output logic [ADDR_W-1:0] tgt_o,
    output logic              valid_o,
    output logic              misalign_o
);
    bt_state_e         state_q, state_d;
    logic [ADDR_W-1:0] sel_tgt;
    logic              sel_mis;

    always_comb begin
        sel_mis = 1'b0;
        unique case (mode_i)
            MODE_REL:    sel_tgt = rel_tgt_i;
            MODE_REGION: sel_tgt = region_tgt_i;
            MODE_REG: begin
                sel_tgt = reg_val_i;
                sel_mis = |reg_val_i[ALIGN_B-1:0];
            end
            MODE_SEQ:    sel_tgt = seq_tgt_i;
            default:     sel_tgt = seq_tgt_i;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i)  state_d = ST_ISSUE;
            ST_ISSUE: if (!req_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_o      <= '0;
            misalign_o <= 1'b0;
        end else if (req_i) begin
            tgt_o      <= sel_tgt;
            misalign_o <= sel_mis;
        end
    end

    assign valid_o = (state_q == ST_ISSUE);

    // R2
    valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);

    // R7
    mis_only_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i != MODE_REG) |=> !misalign_o);

    // R7
    mis_reg_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == MODE_REG) |=>
            (misalign_o == ($past(reg_val_i[ALIGN_B-1:0]) != '0)));

    // R9
    hold_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(tgt_o) && $stable(misalign_o)));

endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
    import bt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int REL_W   = 16,
    parameter int ABS_W   = 26,
    parameter int ALIGN_B = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ABS_W-1:0]  imm_i,
    input  logic [ADDR_W-1:0] reg_i,
    output logic [ADDR_W-1:0] tgt_o,
    output logic              valid_o,
    output logic              misalign_o
);
    localparam int REGION_W    = ADDR_W - ABS_W - ALIGN_B;
    localparam int INSTR_BYTES = 1 << ALIGN_B;

    bt_mode_e          mode;
    logic [ADDR_W-1:0] pc_next;
    logic [ADDR_W-1:0] rel_tgt;
    logic [ADDR_W-1:0] region_tgt;

    assign mode    = bt_mode_e'(mode_i);
    assign pc_next = pc_i + ADDR_W'(INSTR_BYTES);

    bt_rel_calc #(
        .ADDR_W (ADDR_W),
        .REL_W  (REL_W),
        .ALIGN_B(ALIGN_B)
    ) rel_i (
        .base_i(pc_next),
        .off_i (imm_i[REL_W-1:0]),
        .tgt_o (rel_tgt)
    );

    bt_region_calc #(
        .ADDR_W (ADDR_W),
        .ABS_W  (ABS_W),
        .ALIGN_B(ALIGN_B)
    ) region_i (
        .region_i(pc_next[ADDR_W-1 -: REGION_W]),
        .field_i (imm_i),
        .tgt_o   (region_tgt)
    );

    bt_out_stage #(
        .ADDR_W (ADDR_W),
        .ALIGN_B(ALIGN_B)
    ) out_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .mode_i      (mode),
        .rel_tgt_i   (rel_tgt),
        .region_tgt_i(region_tgt),
        .seq_tgt_i   (pc_next),
        .reg_val_i   (reg_i),
        .tgt_o       (tgt_o),
        .valid_o     (valid_o),
        .misalign_o  (misalign_o)
    );

    // R8
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'b11) |=>
            (tgt_o == $past(pc_i + ADDR_W'(INSTR_BYTES))));

    // R5
    region_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'b01) |=>
            (tgt_o[ADDR_W-1 -: REGION_W] ==
             $past(pc_next[ADDR_W-1 -: REGION_W])));

    // R5
    region_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'b01) |=>
            (tgt_o[ADDR_W-REGION_W-1:0] == {$past(imm_i), {ALIGN_B{1'b0}}}));

    // R6
    reg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'b10) |=> (tgt_o == $past(reg_i)));

    // R3
    rel_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'b00 && pc_i[ALIGN_B-1:0] == '0) |=>
            (tgt_o[ALIGN_B-1:0] == '0));

endmodule

// File: tb/branch_target_gen_tb.sv
module branch_target_gen_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [31:0] pc_i = '0;
    logic [25:0] imm_i = '0;
    logic [31:0] reg_i = '0;
    logic [31:0] tgt_o;
    logic        valid_o;
    logic        misalign_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_target_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .mode_i    (mode_i),
        .pc_i      (pc_i),
        .imm_i     (imm_i),
        .reg_i     (reg_i),
        .tgt_o     (tgt_o),
        .valid_o   (valid_o),
        .misalign_o(misalign_o)
    );

    function automatic logic [31:0] model_tgt(input logic [1:0] m, input logic [31:0] pc,
                                              input logic [25:0] imm, input logic [31:0] r);
        logic [31:0] nxt;
        nxt = pc + 32'd4;
        case (m)
            2'b00:   return nxt + {{14{imm[15]}}, imm[15:0], 2'b00};
            2'b01:   return {nxt[31:28], imm, 2'b00};
            2'b10:   return r;
            default: return nxt;
        endcase
    endfunction

    function automatic logic model_mis(input logic [1:0] m, input logic [31:0] r);
        return (m == 2'b10) && (r[1:0] != 2'b00);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; result is checked at the next falling edge
    task automatic issue(input string tag, input logic [1:0] m, input logic [31:0] pc,
                         input logic [25:0] imm, input logic [31:0] r);
        req_i = 1'b1; mode_i = m; pc_i = pc; imm_i = imm; reg_i = r;
        @(posedge clk);
        @(negedge clk);
        check({tag, " R2 valid"}, {31'd0, valid_o}, 32'd1);
        check({tag, " target"}, tgt_o, model_tgt(m, pc, imm, r));
        check({tag, " R7 misalign"}, {31'd0, misalign_o}, {31'd0, model_mis(m, r)});
    endtask

    // R9: idle cycle with scrambled inputs leaves outputs unchanged
    task automatic idle_scrambled();
        logic [31:0] t0;
        logic        m0;
        t0 = tgt_o; m0 = misalign_o;
        req_i = 1'b0; mode_i = 2'b10; pc_i = $urandom; imm_i = 26'($urandom);
        reg_i = $urandom | 32'd3;
        @(posedge clk);
        @(negedge clk);
        check("R2 valid low when idle", {31'd0, valid_o}, 32'd0);
        check("R9 target held", tgt_o, t0);
        check("R9 misalign held", {31'd0, misalign_o}, {31'd0, m0});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 valid in reset", {31'd0, valid_o}, 32'd0);
        check("R1 target in reset", tgt_o, 32'd0);
        check("R1 misalign in reset", {31'd0, misalign_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, valid_o}, 32'd0);
        check("R1 target after reset", tgt_o, 32'd0);

        // R3 forward, backward, most negative
        issue("R3 fwd", 2'b00, 32'h0000_1000, 26'h0000005, 32'h0);
        check("R3 fwd value", tgt_o, 32'h0000_1018);
        issue("R3 back", 2'b00, 32'h0000_1000, 26'h000FFFF, 32'h0);
        check("R3 back value", tgt_o, 32'h0000_1000);
        issue("R3 minneg", 2'b00, 32'h0002_0000, 26'h0008000, 32'h0);
        check("R3 minneg value", tgt_o, 32'h0000_0004);
        // R10 upper immediate bits ignored in relative mode
        issue("R10 upper imm", 2'b00, 32'h0000_0100, 26'h3FF0003, 32'h0);
        check("R10 value", tgt_o, 32'h0000_0110);
        // R4 register value ignored outside register mode
        issue("R4 rel reg junk", 2'b00, 32'h0000_0100, 26'h0000003, 32'hFFFF_FFFF);
        check("R4 rel value", tgt_o, 32'h0000_0110);
        issue("R4 region reg junk", 2'b01, 32'h3000_0000, 26'h0000010, 32'h1234_5677);
        check("R4 region value", tgt_o, 32'h3000_0040);
        issue("R4 seq reg junk", 2'b11, 32'h0000_0040, 26'h3FFFFFF, 32'h0000_0003);
        check("R4 seq value", tgt_o, 32'h0000_0044);
        // R5 region with full field and wrap into region 0
        issue("R5 full field", 2'b01, 32'h7000_0000, 26'h3FFFFFF, 32'h0);
        check("R5 full value", tgt_o, 32'h7FFF_FFFC);
        issue("R5 wrap", 2'b01, 32'hFFFF_FFFC, 26'h0000001, 32'h0);
        check("R5 wrap value", tgt_o, 32'h0000_0004);
        // R6, R7 register mode, every low-bit pattern
        for (int b = 0; b < 4; b++) begin
            issue("R6 reg", 2'b10, 32'h0000_2000, 26'h0, 32'h8000_0040 | 32'(b));
            check("R7 misalign pattern", {31'd0, misalign_o}, {31'd0, (b != 0)});
        end
        idle_scrambled();
        // R8 sequential with wrap
        issue("R8 seq wrap", 2'b11, 32'hFFFF_FFFC, 26'h0, 32'h0);
        check("R8 wrap value", tgt_o, 32'h0000_0000);
        idle_scrambled();
        idle_scrambled();

        // random back-to-back and idle mix
        for (int i = 0; i < 400; i++) begin
            issue("R3 R5 R6 R8 random", 2'($urandom), $urandom, 26'($urandom), $urandom);
            if (($urandom % 4) == 0) idle_scrambled();
        end

        req_i = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule